// File: doc/BRIEF.md
# DDR Mode Register Load Sequencer

This block sits on the controller side of a DDR SDRAM interface. It issues the three mode-register loads that the memory needs before it may be read, either at power-up or after a period with the DLL turned off for debug. A pulse on `start` captures the operating-mode bits and the drive-strength choice. The block then writes the extended register to turn the DLL on. Next it loads the base register with the DLL-reset bit set. Last, it loads the base register again with that bit clear, which selects normal operation.

Each load is a single command cycle on the chip-select, row-strobe, column-strobe and write-enable lines. A load is issued only when the `banks_idle` input says that no bank is open and no burst is running. After each load comes a fixed run of deselect cycles. From the DLL-reset load onward, the block counts the cycles in which the clock-enable pin is high. If the pin drops, the count starts again from zero. Once the count reaches the lock interval and all three loads are done, `read_ok` goes high and stays high until the next `start`. Precharge, refresh and the data path belong to other blocks.

Top module: `ddr_mrs_seq`

## Requirements
- R1: While `rst` is high, and on the cycle after it, the outputs read: `cs_n`, `ras_n`, `cas_n`, `we_n` all 1; `ba` and `addr` zero; `cke` 0; `read_ok` 0.
- R2: A `start` pulse captures `op_mode` and `drive_weak`. No load is issued while `banks_idle` is low. A pending load is issued in the cycle after the first clock edge that sees `banks_idle` high.
- R3: A load command has `cs_n`, `ras_n`, `cas_n` and `we_n` all 0 for exactly one cycle. In every other cycle all four are 1, with `ba` and `addr` zero.
- R4: The first load after `start` targets the extended register. It has `ba`=2'b01, `addr[0]`=0 (DLL on), `addr[1]`=the captured `drive_weak`, and `addr[12:2]` all zero.
- R5: The second load targets the base register with a DLL reset. It has `ba`=2'b00, `addr[8]`=1, `addr[7]`=0, `addr[6:0]`=the captured `op_mode`, and `addr[12:9]` zero.
- R6: The third load targets the base register for normal operation. It has `ba`=2'b00, `addr[8:7]`=0, `addr[6:0]`=the captured `op_mode`, and `addr[12:9]` zero.
- R7: At least TMRD deselect cycles separate two loads. When `banks_idle` stays high, the next load comes exactly TMRD+1 cycles after the previous one.
- R8: The lock count is zero at the edge that issues the DLL-reset load. It then increases by one at each edge where `cke` is 1, up to LOCK_CYC. It returns to zero at each edge where `cke` is 0.
- R9: `read_ok` rises one cycle after the lock count stands at LOCK_CYC, provided the third load has completed its TMRD wait. When `cke` stays high, this is LOCK_CYC+1 cycles after the DLL-reset load. Once high, `read_ok` stays high, even if `cke` drops, until `start`.
- R10: `start` at any point drops `read_ok` on the next cycle and restarts the order from the extended-register load.
- R11: `cke` repeats `cke_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin or restart the load order |
| banks_idle | input | 1 | All banks idle, no burst running |
| cke_req | input | 1 | Requested clock-enable level |
| op_mode | input | 7 | Base-register operating bits for A6:A0 |
| drive_weak | input | 1 | Reduced output drive strength select |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, register select |
| addr | output | 13 | Address bus, register contents |
| cke | output | 1 | Clock enable to the memory |
| read_ok | output | 1 | READ commands are now legal |

## Verification
A load appears on the pins one cycle after the edge that accepts it. The next load follows TMRD+1 cycles later. `cke` lags `cke_req` by one cycle. `read_ok` rises LOCK_CYC+1 cycles after the DLL-reset load when `cke` stays high. The bench steps a behavioural model at each rising edge, using the inputs it drove at the previous falling edge. It then compares every output with that model at the next falling edge, so each result is checked in the cycle it is due. Further directed checks measure the load spacing, the lock-to-ready distance and the absence of loads while the banks are busy.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;
  localparam int ADDR_W = 13;
  localparam int OPS_W  = 7;
  localparam int DLLRST_BIT = 8;

  typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_MRD, ST_DONE} seq_st_t;
  typedef enum logic [1:0] {LD_EXT, LD_DLLRST, LD_NORM} load_t;

  typedef struct packed {
    logic              cs_n;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [1:0]        ba;
    logic [ADDR_W-1:0] addr;
  } ddr_cmd_t;

  function automatic ddr_cmd_t deselect_cmd();
    ddr_cmd_t c;
    c.cs_n  = 1'b1;
    c.ras_n = 1'b1;
    c.cas_n = 1'b1;
    c.we_n  = 1'b1;
    c.ba    = '0;
    c.addr  = '0;
    return c;
  endfunction
endpackage

// File: rtl/mrs_word_gen.sv
module mrs_word_gen
  import ddr_mrs_pkg::*;
(
  input  load_t            sel,
  input  logic [OPS_W-1:0] ops,
  input  logic             drive_weak,
  output ddr_cmd_t         word
);
  always_comb begin
    word       = deselect_cmd();
    word.cs_n  = 1'b0;
    word.ras_n = 1'b0;
    word.cas_n = 1'b0;
    word.we_n  = 1'b0;
    case (sel)
      LD_EXT: begin
        word.ba      = 2'b01;
        word.addr[0] = 1'b0;
        word.addr[1] = drive_weak;
      end
      LD_DLLRST: begin
        word.ba                = 2'b00;
        word.addr[OPS_W-1:0]   = ops;
        word.addr[DLLRST_BIT]  = 1'b1;
      end
      default: begin
        word.ba              = 2'b00;
        word.addr[OPS_W-1:0] = ops;
      end
    endcase
  end
endmodule

// File: rtl/mrs_seq_fsm.sv
module mrs_seq_fsm
  import ddr_mrs_pkg::*;
#(
  parameter int TMRD = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  banks_idle,
  output logic  issue,
  output load_t step,
  output logic  seq_done
);
  localparam int WW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [WW-1:0] WAIT_LOAD = WW'(TMRD - 1);

  seq_st_t        st;
  logic [WW-1:0]  wcnt;

  assign issue = (st == ST_WAIT) && banks_idle && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_OFF;
      step     <= LD_EXT;
      wcnt     <= '0;
      seq_done <= 1'b0;
    end else if (start) begin
      st       <= ST_WAIT;
      step     <= LD_EXT;
      seq_done <= 1'b0;
    end else begin
      case (st)
        ST_WAIT: if (banks_idle) begin
          st   <= ST_MRD;
          wcnt <= WAIT_LOAD;
        end
        ST_MRD: if (wcnt == '0) begin
          case (step)
            LD_EXT:    begin step <= LD_DLLRST; st <= ST_WAIT; end
            LD_DLLRST: begin step <= LD_NORM;   st <= ST_WAIT; end
            default:   begin st <= ST_DONE; seq_done <= 1'b1; end
          endcase
        end else begin
          wcnt <= wcnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R7: the wait counter never exceeds its load value
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (rst)
    wcnt <= WAIT_LOAD);
  // R6: done only follows the normal-mode step
  p_done_after_norm_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_done) |-> step == LD_NORM);
endmodule

// File: rtl/mrs_lock_timer.sv
module mrs_lock_timer #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dll_rst,
  input  logic cke,
  input  logic seq_done,
  output logic read_ok
);
  localparam int LCW = $clog2(LOCK_CYC + 1);
  localparam logic [LCW-1:0] LOCK_V = LCW'(LOCK_CYC);

  logic           run;
  logic [LCW-1:0] lcnt;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      run     <= 1'b0;
      lcnt    <= '0;
      read_ok <= 1'b0;
    end else begin
      if (dll_rst) begin
        run  <= 1'b1;
        lcnt <= '0;
      end else if (run) begin
        if (!cke)               lcnt <= '0;
        else if (lcnt != LOCK_V) lcnt <= lcnt + 1'b1;
      end
      if (seq_done && lcnt == LOCK_V) read_ok <= 1'b1;
    end
  end

  p_lock_bound_r8: assert property (@(posedge clk) disable iff (rst)
    lcnt <= LOCK_V);
  p_cke_restart_r8: assert property (@(posedge clk) disable iff (rst)
    run && !cke && !start && !dll_rst |=> lcnt == '0);
  p_ok_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(read_ok) |-> $past(lcnt) == LOCK_V);
  p_ok_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    read_ok && !start |=> read_ok);
endmodule

// File: rtl/ddr_mrs_seq.sv
module ddr_mrs_seq
  import ddr_mrs_pkg::*;
#(
  parameter int TMRD     = 2,
  parameter int LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              banks_idle,
  input  logic              cke_req,
  input  logic [OPS_W-1:0]  op_mode,
  input  logic              drive_weak,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              read_ok
);
  logic [OPS_W-1:0] ops_q;
  logic             weak_q;
  logic             issue;
  logic             seq_done;
  load_t            step;
  ddr_cmd_t         word;
  ddr_cmd_t         pins_q;

  mrs_seq_fsm #(.TMRD(TMRD)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .banks_idle(banks_idle),
    .issue(issue), .step(step), .seq_done(seq_done)
  );

  mrs_word_gen u_word (
    .sel(step), .ops(ops_q), .drive_weak(weak_q), .word(word)
  );

  mrs_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .start(start),
    .dll_rst(issue && step == LD_DLLRST),
    .cke(cke), .seq_done(seq_done), .read_ok(read_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ops_q  <= '0;
      weak_q <= 1'b0;
      pins_q <= deselect_cmd();
      cke    <= 1'b0;
    end else begin
      if (start) begin
        ops_q  <= op_mode;
        weak_q <= drive_weak;
      end
      pins_q <= issue ? word : deselect_cmd();
      cke    <= cke_req;
    end
  end

  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
  assign ba    = pins_q.ba;
  assign addr  = pins_q.addr;

  logic load_seen;
  assign load_seen = !cs_n && !ras_n && !cas_n && !we_n;

  p_one_cycle_load_r3: assert property (@(posedge clk) disable iff (rst)
    load_seen |=> cs_n && ras_n && cas_n && we_n);
  p_load_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    load_seen |-> $past(banks_idle));
  p_ext_reserved_r4: assert property (@(posedge clk) disable iff (rst)
    load_seen && ba == 2'b01 |-> addr[ADDR_W-1:2] == '0 && !addr[0]);
  p_cke_follow_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cke == $past(cke_req));
endmodule

// File: tb/test_ddr_mrs_seq.sv
module test_ddr_mrs_seq;
  localparam int TMRD = 2;
  localparam int LOCK = 200;

  logic clk = 0, rst = 1, start = 0, banks_idle = 0, cke_req = 0, drive_weak = 0;
  logic [6:0] op_mode = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, read_ok;
  logic [1:0] ba;
  logic [12:0] addr;

  int checks = 0, errors = 0, cyc = 0;

  ddr_mrs_seq #(.TMRD(TMRD), .LOCK_CYC(LOCK)) i_ddr_mrs_seq (
    .clk(clk), .rst(rst), .start(start), .banks_idle(banks_idle),
    .cke_req(cke_req), .op_mode(op_mode), .drive_weak(drive_weak),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cke(cke), .read_ok(read_ok)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected pin vector {cs,ras,cas,we,ba,addr} for a load step
  function automatic logic [18:0] load_vec(input int s, input logic [6:0] o, input logic w);
    logic [12:0] a = '0;
    logic [1:0]  b = 2'b00;
    if (s == 0) begin b = 2'b01; a[1] = w; end
    else begin a[6:0] = o; a[8] = (s == 1); end
    return {4'b0000, b, a};
  endfunction

  // behavioural reference
  int m_ph, m_step, m_w, m_lc;
  bit m_done, m_lrun, m_ok, m_cke, m_load;
  int m_lstep;
  logic [6:0] m_ops;
  logic m_weak;
  bit model_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_step = 0; m_w = 0; m_lc = 0; m_done = 0; m_lrun = 0;
      m_ok = 0; m_cke = 0; m_load = 0; m_lstep = 0; m_ops = '0; m_weak = 0;
    end else begin
      bit iss, o_done, o_cke;
      int o_lc;
      iss = (m_ph == 1) && banks_idle && !start;
      o_done = m_done; o_cke = m_cke; o_lc = m_lc;
      if (start) begin m_lrun = 0; m_lc = 0; m_ok = 0; end
      else begin
        if (iss && m_step == 1) begin m_lrun = 1; m_lc = 0; end
        else if (m_lrun) m_lc = o_cke ? ((m_lc < LOCK) ? m_lc + 1 : m_lc) : 0;
        if (o_done && o_lc == LOCK) m_ok = 1;
      end
      m_cke = cke_req;
      m_load = iss; m_lstep = m_step;
      if (start) begin
        m_ph = 1; m_step = 0; m_done = 0; m_ops = op_mode; m_weak = drive_weak;
      end else if (m_ph == 1) begin
        if (banks_idle) begin m_ph = 2; m_w = TMRD - 1; end
      end else if (m_ph == 2) begin
        if (m_w == 0) begin
          if (m_step == 2) begin m_ph = 3; m_done = 1; end
          else begin m_step++; m_ph = 1; end
        end else m_w--;
      end
    end
    model_on = 1;
  end

  int loads = 0, last_load = -1000, rst_load_cyc = -1, ok_rise_cyc = -1;
  bit prev_ok = 0;

  always @(negedge clk) begin
    cyc++;
    if (model_on) begin
      logic [18:0] act, exp;
      act = {cs_n, ras_n, cas_n, we_n, ba, addr};
      exp = m_load ? load_vec(m_lstep, m_ops, m_weak) : {4'b1111, 15'b0};
      case (m_load ? m_lstep : -1)
        0: check(act == exp, "R4", act, exp);
        1: check(act == exp, "R5", act, exp);
        2: check(act == exp, "R6", act, exp);
        default: check(act == exp, "R3", act, exp);
      endcase
      check(cke == m_cke, "R11", cke, m_cke);
      check(read_ok == m_ok, "R9", read_ok, m_ok);
      if (act[18:15] == 4'b0000) begin
        loads++;
        if (last_load >= 0) check(cyc - last_load >= TMRD + 1, "R7", cyc - last_load, TMRD + 1);
        last_load = cyc;
        if (ba == 2'b00 && addr[8]) rst_load_cyc = cyc;
      end
      if (read_ok && !prev_ok) ok_rise_cyc = cyc;
      prev_ok = read_ok;
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start(input logic [6:0] o, input logic w);
    op_mode = o; drive_weak = w; start = 1;
    ticks(1);
    start = 0; op_mode = '0; drive_weak = 0;
  endtask

  initial begin
    ticks(4);
    check(cs_n && ras_n && cas_n && we_n && ba == 0 && addr == 0, "R1", {cs_n, ras_n, cas_n, we_n}, 4'hf);
    check(cke == 0 && read_ok == 0, "R1", {cke, read_ok}, 0);
    rst = 0;
    ticks(1);
    check(read_ok == 0 && cs_n, "R1", {read_ok, cs_n}, 1);

    // A: clean sequence
    cke_req = 1; banks_idle = 1; last_load = -1000;
    pulse_start(7'h32, 0);
    ticks(230);
    check(read_ok == 1, "R9", read_ok, 1);
    check(ok_rise_cyc - rst_load_cyc == LOCK + 1, "R9", ok_rise_cyc - rst_load_cyc, LOCK + 1);
    check(loads == 3, "R6", loads, 3);
    cke_req = 0; ticks(5);
    check(read_ok == 1, "R9", read_ok, 1);

    // B: busy banks, cke drop in lock window
    cke_req = 1; banks_idle = 0; loads = 0; last_load = -1000;
    pulse_start(7'h5A, 1);
    check(read_ok == 0, "R10", read_ok, 0);
    ticks(12);
    check(loads == 0, "R2", loads, 0);
    banks_idle = 1; ticks(3);
    banks_idle = 0; ticks(4);
    banks_idle = 1; ticks(100);
    cke_req = 0; ticks(3);
    cke_req = 1; ticks(310);
    check(loads == 3, "R8", loads, 3);

    // D: restart mid-sequence
    loads = 0; last_load = -1000;
    pulse_start(7'h11, 0);
    ticks(4);
    pulse_start(7'h6C, 1);
    last_load = -1000;
    ticks(240);
    check(read_ok == 1, "R10", read_ok, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule